// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer on a small register bus. Software starts it and keeps it alive by writing magic values to a write-only key register. The prescaler and reload registers can be changed only after a separate unlock key has been written. Once the watchdog is started it cannot be stopped; if software fails to refresh it in time, the block pulses a reset request for one clock.

A register write does not reach the counter at once. Each written value sits in a shadow register for a fixed number of cycles, set by a parameter, which stands in for the hand-over to a slow watchdog clock. During that time a busy bit in the status register is set. The expected software sequence is: unlock, write the prescaler, write the reload value, write the start key, poll until both busy bits are clear, then refresh.

Two small state machines set the behaviour. The counter machine has the states WD_IDLE and WD_RUN. It moves from WD_IDLE to WD_RUN on the start key, and WD_RUN only loops back to itself. Each configuration register has an update machine with the states UPD_IDLE and UPD_WAIT. A write accepted in either state enters UPD_WAIT and restarts the delay. UPD_WAIT returns to UPD_IDLE when the delay runs out, and the shadow value is then applied.

Top module: `key_wdog`

## Requirements
- R1: After reset, rst_o is 0 and status reads 0. The prescaler reads 0, the reload register reads 0xFFF and the window register reads 0xFFF. The key register always reads 0. No pulse appears without a start key.
- R2: Register offsets are key 0x00, prescaler 0x04, reload 0x08, status 0x0C and window 0x10. Writes to the prescaler, reload or window register are ignored while write access is locked. Write access is locked after reset and after key 0x0000.
- R3: Key 0x5555 unlocks write access. An accepted prescaler or reload write reads back at once, and its busy bit is set. The busy bit reads 1 for exactly SYNC_CYC cycles after the write edge, and the value is applied to the counter when the bit clears.
- R4: Key 0xCCCC starts the watchdog. With divider D and reload value L, rst_o is 1 exactly (L+1)*D cycles after the start-key write edge. It stays high for one cycle and then repeats with the same period.
- R5: Key 0xAAAA reloads the down-counter from the applied reload value and restarts the prescaler. The next pulse is then due (L+1)*D cycles after the refresh edge.
- R6: Prescaler code c (bits [PR_W-1:0]) selects a divider of 4<<c. Codes above log2(MAX_DIV)-2 divide by MAX_DIV.
- R7: Once running, the watchdog cannot be stopped by any key write. Key values other than the four defined keys have no effect, including no unlock.
- R8: The reload register is 12 bits wide; write data bits [15:12] are dropped.
- R9: Status bit 0 is the prescaler busy bit and status bit 1 is the reload busy bit, and each follows only its own register.
- R10: An accepted write to the window register is stored and read back. It has no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
Read data is combinational, so the bench reads a register in the same low clock phase in which it sets the address. A write takes effect at the rising edge that follows it, and a busy bit is sampled after edges 1 to SYNC_CYC following the write. It must read 1 after the first SYNC_CYC-1 of those edges and 0 after the last one. The reset pulse is registered at the edge of the final prescaled tick. The bench therefore counts rising edges from the start or refresh write and expects rst_o to be high after exactly (L+1)*D of them, minus one for every further write that used up an edge in between.

// File: rtl/key_wdog_pkg.sv
package key_wdog_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFS_KEY    = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRESC  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_WINDOW = 5'h10;

    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_LOCK    = 16'h0000;

    typedef enum logic {WD_IDLE, WD_RUN} wd_state_t;
    typedef enum logic {UPD_IDLE, UPD_WAIT} upd_state_t;
endpackage

// File: rtl/kw_sync_slot.sv
module kw_sync_slot #(
    parameter int W        = 12,
    parameter int SYNC_CYC = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] applied,
    output logic         busy
);
    import key_wdog_pkg::*;

    localparam int CNT_W = $clog2(SYNC_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SYNC_CYC);

    upd_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE: if (wr) state_d = UPD_WAIT;
            UPD_WAIT: if (!wr && cnt_q == CNT_W'(1)) state_d = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shadow  <= RST_VAL;
            applied <= RST_VAL;
        end else if (wr) begin
            cnt_q  <= CNT_LOAD;
            shadow <= wdata;
        end else if (state_q == UPD_WAIT) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) applied <= shadow;
        end
    end

    always_comb busy = (state_q == UPD_WAIT);

    // R3: when the busy bit drops, the counter side holds the written value
    assert_applied_on_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> applied == shadow);
endmodule

// File: rtl/kw_regs.sv
module kw_regs #(
    parameter int RLD_W    = 12,
    parameter int PR_W     = 3,
    parameter int SYNC_CYC = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_we,
    input  logic [key_wdog_pkg::ADDR_W-1:0]   bus_addr,
    input  logic [key_wdog_pkg::DATA_W-1:0]   bus_wdata,
    output logic [key_wdog_pkg::DATA_W-1:0]   bus_rdata,
    output logic                              start_o,
    output logic                              refresh_o,
    output logic [PR_W-1:0]                   pr_code_o,
    output logic [RLD_W-1:0]                  reload_o
);
    import key_wdog_pkg::*;

    logic             unlock_q;
    logic [RLD_W-1:0] window_q;
    logic             key_wr, pr_wr, rl_wr, win_wr;
    logic [PR_W-1:0]  pr_shadow;
    logic [RLD_W-1:0] rl_shadow;
    logic             pr_busy, rl_busy;

    always_comb begin
        key_wr    = bus_we && bus_addr == OFS_KEY;
        pr_wr     = bus_we && bus_addr == OFS_PRESC  && unlock_q;
        rl_wr     = bus_we && bus_addr == OFS_RELOAD && unlock_q;
        win_wr    = bus_we && bus_addr == OFS_WINDOW && unlock_q;
        start_o   = key_wr && bus_wdata == KEY_START;
        refresh_o = key_wr && bus_wdata == KEY_REFRESH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q <= 1'b0;
            window_q <= {RLD_W{1'b1}};
        end else begin
            if (key_wr) begin
                case (bus_wdata)
                    KEY_UNLOCK: unlock_q <= 1'b1;
                    KEY_LOCK:   unlock_q <= 1'b0;
                    default:    unlock_q <= unlock_q;
                endcase
            end
            if (win_wr) window_q <= bus_wdata[RLD_W-1:0];
        end
    end

    kw_sync_slot #(.W(PR_W), .SYNC_CYC(SYNC_CYC), .RST_VAL('0)) u_pr (
        .clk(clk), .rst_n(rst_n), .wr(pr_wr), .wdata(bus_wdata[PR_W-1:0]),
        .shadow(pr_shadow), .applied(pr_code_o), .busy(pr_busy));

    kw_sync_slot #(.W(RLD_W), .SYNC_CYC(SYNC_CYC), .RST_VAL({RLD_W{1'b1}})) u_rl (
        .clk(clk), .rst_n(rst_n), .wr(rl_wr), .wdata(bus_wdata[RLD_W-1:0]),
        .shadow(rl_shadow), .applied(reload_o), .busy(rl_busy));

    always_comb begin
        unique case (bus_addr)
            OFS_PRESC:  bus_rdata = {{(DATA_W-PR_W){1'b0}}, pr_shadow};
            OFS_RELOAD: bus_rdata = {{(DATA_W-RLD_W){1'b0}}, rl_shadow};
            OFS_STATUS: bus_rdata = {{(DATA_W-2){1'b0}}, rl_busy, pr_busy};
            OFS_WINDOW: bus_rdata = {{(DATA_W-RLD_W){1'b0}}, window_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R2: a locked write to a configuration register leaves it untouched
    assert_locked_presc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_PRESC && !unlock_q) |=> $stable(pr_shadow));
    assert_locked_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_RELOAD && !unlock_q) |=> $stable(rl_shadow));
endmodule

// File: rtl/kw_counter.sv
module kw_counter #(
    parameter int RLD_W    = 12,
    parameter int PR_W     = 3,
    parameter int MAX_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             refresh,
    input  logic [PR_W-1:0]  pr_code,
    input  logic [RLD_W-1:0] reload,
    output logic             rst_o
);
    import key_wdog_pkg::*;

    localparam int DIV_W = MAX_CODE + 3;
    localparam logic [PR_W-1:0] CODE_CAP = PR_W'(MAX_CODE);

    wd_state_t state_q, state_d;
    logic [DIV_W-1:0] psc_q, div_m1;
    logic [PR_W-1:0]  eff_code;
    logic [RLD_W-1:0] count_q;
    logic             pulse_q;

    always_comb begin
        eff_code = (pr_code > CODE_CAP) ? CODE_CAP : pr_code;
        div_m1   = (DIV_W'(4) << eff_code) - DIV_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: if (start) state_d = WD_RUN;
            WD_RUN:  state_d = WD_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q   <= '0;
            count_q <= {RLD_W{1'b1}};
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (start || refresh) begin
                psc_q   <= '0;
                count_q <= reload;
            end else if (state_q == WD_RUN) begin
                if (psc_q >= div_m1) begin
                    psc_q <= '0;
                    if (count_q == '0) begin
                        count_q <= reload;
                        pulse_q <= 1'b1;
                    end else begin
                        count_q <= count_q - RLD_W'(1);
                    end
                end else begin
                    psc_q <= psc_q + DIV_W'(1);
                end
            end
        end
    end

    always_comb rst_o = pulse_q;

    // R4: the reset request lasts a single cycle
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o);
    // R1: no reset request before the watchdog has been started
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_IDLE) |-> !rst_o);
    // R7: the running state never ends
    assert_run_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN) |=> (state_q == WD_RUN));
endmodule

// File: rtl/key_wdog.sv
module key_wdog #(
    parameter int MAX_DIV  = 256,
    parameter int SYNC_CYC = 3,
    parameter int RLD_W    = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        rst_o
);
    localparam int MAX_CODE = $clog2(MAX_DIV) - 2;
    localparam int PR_W     = $clog2(MAX_CODE + 1);

    logic             start_k, refresh_k;
    logic [PR_W-1:0]  pr_code;
    logic [RLD_W-1:0] reload_v;

    kw_regs #(.RLD_W(RLD_W), .PR_W(PR_W), .SYNC_CYC(SYNC_CYC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start_o(start_k),
        .refresh_o(refresh_k), .pr_code_o(pr_code), .reload_o(reload_v));

    kw_counter #(.RLD_W(RLD_W), .PR_W(PR_W), .MAX_CODE(MAX_CODE)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start_k), .refresh(refresh_k),
        .pr_code(pr_code), .reload(reload_v), .rst_o(rst_o));
endmodule

// File: tb/sim_key_wdog.sv
`timescale 1ns/1ps
module sim_key_wdog;
    localparam int SYNC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_o;
    int          checks = 0;
    int          errors = 0;

    key_wdog #(.MAX_DIV(256), .SYNC_CYC(SYNC), .RLD_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_o(rst_o));

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called in the low phase; uses up one rising edge
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        bus_addr = a; #1; v = int'(bus_rdata);
    endtask

    task automatic edges(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        while (n < 5000) begin
            @(posedge clk); n++; @(negedge clk);
            if (rst_o) break;
        end
    endtask

    task automatic wait_idle();
        int v = 3;
        for (int k = 0; k < 50 && v != 0; k++) begin rd(5'h0C, v); if (v != 0) edges(1); end
    endtask

    task automatic t_reset();
        int v, seen;
        rd(5'h0C, v); check("R1 status", v, 0);
        rd(5'h04, v); check("R1 prescaler", v, 0);
        rd(5'h08, v); check("R1 reload", v, 12'hFFF);
        rd(5'h10, v); check("R1 window", v, 12'hFFF);
        rd(5'h00, v); check("R1 key reads zero", v, 0);
        seen = 0;
        for (int k = 0; k < 200; k++) begin edges(1); if (rst_o) seen++; end
        check("R1 no pulse when idle", seen, 0);
    endtask

    task automatic t_locked();
        int v;
        wr(5'h04, 16'h0003); rd(5'h04, v); check("R2 locked prescaler", v, 0);
        wr(5'h00, 16'h1234);
        wr(5'h08, 16'h0005); rd(5'h08, v); check("R7 unknown key no unlock", v, 12'hFFF);
        rd(5'h0C, v); check("R2 no busy when locked", v, 0);
    endtask

    task automatic t_unlock_busy();
        int v;
        wr(5'h00, 16'h5555);
        wr(5'h04, 16'h0000);
        rd(5'h0C, v); check("R9 prescaler busy only", v, 1);
        for (int k = 1; k < SYNC; k++) begin edges(1); rd(5'h0C, v); check("R3 busy held", v, 1); end
        edges(1); rd(5'h0C, v); check("R3 busy cleared after SYNC_CYC", v, 0);
        wr(5'h08, 16'hF002);
        rd(5'h08, v); check("R8 reload 12 bits", v, 12'h002);
        rd(5'h0C, v); check("R9 reload busy only", v, 2);
        wait_idle();
        wr(5'h10, 16'h0ABC); rd(5'h10, v); check("R10 window stored", v, 12'hABC);
        wr(5'h00, 16'h0000);
        wr(5'h08, 16'h0007); rd(5'h08, v); check("R2 relocked reload", v, 2);
        wr(5'h10, 16'h0123); rd(5'h10, v); check("R2 relocked window", v, 12'hABC);
    endtask

    task automatic t_start();
        int n;
        wr(5'h00, 16'hCCCC);
        wait_pulse(n); check("R4 first pulse (2+1)*4", n, 12);
        edges(1); check("R4 pulse one cycle", int'(rst_o), 0);
        wait_pulse(n); check("R4 period", n, 11);
    endtask

    task automatic t_refresh();
        int n;
        edges(5);
        wr(5'h00, 16'hAAAA);
        wait_pulse(n); check("R5 refresh restarts count", n, 12);
    endtask

    task automatic t_nostop();
        int n;
        edges(3);
        wr(5'h00, 16'hAAAA);
        wr(5'h00, 16'h0000);
        wr(5'h00, 16'h4321);
        wait_pulse(n); check("R7 keys cannot stop", n, 10);
    endtask

    task automatic t_presc();
        int n;
        wr(5'h00, 16'h5555);
        wr(5'h04, 16'h0001);
        wait_idle();
        wr(5'h00, 16'hAAAA);
        wait_pulse(n); check("R6 code 1 divides by 8", n, 24);
        wr(5'h04, 16'h0007);
        wr(5'h08, 16'h0000);
        wait_idle();
        wr(5'h00, 16'hAAAA);
        wait_pulse(n); check("R6 code above max clamps to 256", n, 256);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_locked();
        t_unlock_busy();
        t_start();
        t_refresh();
        t_nostop();
        t_presc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule